// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO

This block moves a stream of data words from one clock domain to another whose clock is unrelated to it. A producer in the write domain offers a word with `wr_push` whenever `wr_full` is low. A consumer in the read domain sees the oldest stored word on `rd_data` whenever `rd_empty` is low, and takes it with `rd_pop`. No read-enable cycle is needed: the head entry is driven straight from a flop array at the current read address.

Each domain keeps its own pointer as a binary count and a registered Gray copy. The pointer is one bit wider than the storage address, and the extra top bit counts wraps. Each Gray copy crosses to the other domain through a two-stage synchroniser. Both flags are registered from the *next* Gray value of the local pointer, compared with the synchronised pointer from the other domain. As a result each flag rises on the same edge that fills or drains the last slot. It falls only after the other side's move has crossed, so the flags err on the safe side.

Each domain also has a registered fill level, made by converting the synchronised Gray pointer back to binary and subtracting. The parameter `LEVEL_EN` selects whether these levels are driven or tied to zero.

Top module: `gcx_fifo`

## Requirements
- R1: After reset, `rd_empty` is 1, `wr_full` is 0, and both `wr_level` and `rd_level` are 0.
- R2: Words come out on `rd_data` in the order they were accepted. While `rd_empty` is 0, `rd_data` already shows the oldest word, with no enable cycle.
- R3: With no reads, `wr_full` stays 0 after DEPTH-1 accepted pushes. It reads 1 directly after the clock edge that accepts the DEPTH-th push.
- R4: A push while `wr_full` is 1 is dropped. Stored words are unchanged, the oldest word is still the first one written, and `wr_level` stays at DEPTH.
- R5: A pop while `rd_empty` is 1 is dropped. The read pointer does not move, so a word written later is presented and counted as the only entry.
- R6: `rd_empty` rises directly after the edge that pops the last word. After a write, it stays 1 for at least the next read-clock edge, because of the synchroniser delay.
- R7: `wr_full` stays 1 just after the first pop from a full FIFO. It returns to 0 within a few write-clock cycles once that pop has crossed.
- R8: `wr_level` equals accepted pushes minus synchronised pops, and `rd_level` equals synchronised pushes minus accepted pops. Each is at most DEPTH. A level of DEPTH goes with `wr_full`, and a level of 0 goes with `rd_empty`.
- R9: Each domain's registered Gray pointer changes in at most one bit per clock cycle of that domain.
- R10: Under concurrent traffic with both sides stalling at times, the data stays intact across many wraps of both pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain reset, active low |
| wr_push | input | 1 | Store `wr_data` this cycle unless full |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No free slot, as seen by the write domain |
| wr_level | output | ADDR_W+1 | Occupancy as seen by the write domain |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain reset, active low |
| rd_pop | input | 1 | Consume the presented word this cycle unless empty |
| rd_data | output | DATA_W | Oldest stored word, combinational from the read address |
| rd_empty | output | 1 | Nothing stored, as seen by the read domain |
| rd_level | output | ADDR_W+1 | Occupancy as seen by the read domain |

## Verification
The bench aims at the edges of the pointer range. It fills to exactly DEPTH, pushes into a full FIFO, pops from an empty one, and streams past several pointer wraps. A wrong full test, such as one that ignores the second Gray bit, would either flag full a slot early or let a push overwrite the oldest word; the bench sees this as a shifted `rd_data` sequence. A pop that is not blocked while empty would leave the read pointer ahead of the write pointer, so a later word would show up with the wrong value or level. A flag formed from the current pointer rather than the next one would lag the last push or pop by one cycle, and the bench samples exactly on that cycle.

// File: rtl/gcx_pkg.sv
package gcx_pkg;

    // Number of flop stages in each pointer synchroniser.
    localparam int SYNC_DEPTH = 2;

    // Binary to reflected Gray code, zero-extended to 32 bits.
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code to binary: each bit is the XOR of itself and all higher Gray bits.
    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/gcx_sync.sv
module gcx_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    import gcx_pkg::*;

    logic [W-1:0] stage_d [SYNC_DEPTH];
    logic [W-1:0] stage_q [SYNC_DEPTH];

    always_comb begin
        stage_d[0] = d;
        for (int i = 1; i < SYNC_DEPTH; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_DEPTH; i++) stage_q[i] <= '0;
        end else begin
            for (int i = 0; i < SYNC_DEPTH; i++) stage_q[i] <= stage_d[i];
        end
    end

    assign q = stage_q[SYNC_DEPTH-1];

endmodule

// File: rtl/gcx_store.sv
module gcx_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge wclk) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/gcx_wptr.sv
module gcx_wptr #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W:0]   rgray_sync,
    output logic              full,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic [ADDR_W:0]   gray,
    output logic [ADDR_W:0]   level
);
    import gcx_pkg::*;

    localparam int P     = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    // Gray distance of a full FIFO: top two bits differ, the rest match.
    localparam logic [P-1:0] FULL_XOR = {2'b11, {(P-2){1'b0}}};

    typedef struct packed {
        logic [P-1:0] bin;
        logic [P-1:0] gray;
        logic         full;
        logic [P-1:0] level;
    } wstate_t;

    wstate_t s_d, s_q;
    logic    accept;

    always_comb begin
        s_d        = s_q;
        accept     = push & ~s_q.full;
        s_d.bin    = s_q.bin + P'(accept);
        s_d.gray   = P'(to_gray(32'(s_d.bin)));
        s_d.full   = ((s_d.gray ^ rgray_sync) == FULL_XOR);
        s_d.level  = s_d.bin - P'(from_gray(32'(rgray_sync)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign full  = s_q.full;
    assign we    = accept;
    assign addr  = s_q.bin[ADDR_W-1:0];
    assign gray  = s_q.gray;
    assign level = s_q.level;

    // R4: a push against a full FIFO leaves the pointer where it was
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.full && push) |=> $stable(s_q.bin));
    // R8: occupancy never exceeds the depth
    a_r8_wlevel_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.level <= P'(DEPTH));
    // R8: the full flag and a level of DEPTH go together
    a_r8_full_level: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.full |-> (s_q.level == P'(DEPTH)));
    // R9: the crossing Gray value moves by at most one bit per cycle
    a_r9_wgray_step: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(s_q.gray ^ $past(s_q.gray)) <= 1);

endmodule

// File: rtl/gcx_rptr.sv
module gcx_rptr #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop,
    input  logic [ADDR_W:0]   wgray_sync,
    output logic              empty,
    output logic [ADDR_W-1:0] addr,
    output logic [ADDR_W:0]   gray,
    output logic [ADDR_W:0]   level
);
    import gcx_pkg::*;

    localparam int P     = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [P-1:0] bin;
        logic [P-1:0] gray;
        logic         empty;
        logic [P-1:0] level;
    } rstate_t;

    rstate_t s_d, s_q;
    logic    take;

    always_comb begin
        s_d        = s_q;
        take       = pop & ~s_q.empty;
        s_d.bin    = s_q.bin + P'(take);
        s_d.gray   = P'(to_gray(32'(s_d.bin)));
        s_d.empty  = (s_d.gray == wgray_sync);
        s_d.level  = P'(from_gray(32'(wgray_sync))) - s_d.bin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.empty <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign empty = s_q.empty;
    assign addr  = s_q.bin[ADDR_W-1:0];
    assign gray  = s_q.gray;
    assign level = s_q.level;

    // R5: a pop against an empty FIFO leaves the pointer where it was
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.empty && pop) |=> $stable(s_q.bin));
    // R8: read-side occupancy never exceeds the depth
    a_r8_rlevel_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.level <= P'(DEPTH));
    // R8: the empty flag and a level of zero go together
    a_r8_empty_level: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.empty |-> (s_q.level == '0));
    // R9: the crossing Gray value moves by at most one bit per cycle
    a_r9_rgray_step: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(s_q.gray ^ $past(s_q.gray)) <= 1);

endmodule

// File: rtl/gcx_fifo.sv
module gcx_fifo #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 4,
    parameter bit LEVEL_EN = 1'b1
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_push,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    output logic [ADDR_W:0]   wr_level,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty,
    output logic [ADDR_W:0]   rd_level
);
    localparam int P = ADDR_W + 1;

    logic              we;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [P-1:0]      wgray, rgray, wgray_rs, rgray_ws;
    logic [P-1:0]      wlvl, rlvl;

    gcx_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .wclk  (wr_clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (rd_data)
    );

    gcx_wptr #(.ADDR_W(ADDR_W)) u_wptr (
        .clk        (wr_clk),
        .rst_n      (wr_rst_n),
        .push       (wr_push),
        .rgray_sync (rgray_ws),
        .full       (wr_full),
        .we         (we),
        .addr       (waddr),
        .gray       (wgray),
        .level      (wlvl)
    );

    gcx_rptr #(.ADDR_W(ADDR_W)) u_rptr (
        .clk        (rd_clk),
        .rst_n      (rd_rst_n),
        .pop        (rd_pop),
        .wgray_sync (wgray_rs),
        .empty      (rd_empty),
        .addr       (raddr),
        .gray       (rgray),
        .level      (rlvl)
    );

    gcx_sync #(.W(P)) u_sync_w2r (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (wgray),
        .q     (wgray_rs)
    );

    gcx_sync #(.W(P)) u_sync_r2w (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     (rgray),
        .q     (rgray_ws)
    );

    generate
        if (LEVEL_EN) begin : g_level
            assign wr_level = wlvl;
            assign rd_level = rlvl;
        end else begin : g_nolevel
            assign wr_level = '0;
            assign rd_level = '0;
        end
    endgenerate

endmodule

// File: tb/gcx_fifo_test.sv
`timescale 1ns/100ps
module gcx_fifo_test;

    localparam int DW    = 8;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int N_STREAM = 100;

    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic          wr_push = 1'b0, rd_pop = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          wr_full, rd_empty;
    logic [AW:0]   wr_level, rd_level;

    int n_cmp = 0;
    int n_bad = 0;

    always #10   wr_clk = ~wr_clk;   // 50 MHz write clock
    always #15.5 rd_clk = ~rd_clk;   // unrelated read clock

    gcx_fifo #(.DATA_W(DW), .ADDR_W(AW), .LEVEL_EN(1'b1)) uut (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .wr_push  (wr_push),
        .wr_data  (wr_data),
        .wr_full  (wr_full),
        .wr_level (wr_level),
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .rd_pop   (rd_pop),
        .rd_data  (rd_data),
        .rd_empty (rd_empty),
        .rd_level (rd_level)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr_cycle();
        @(posedge wr_clk);
        #1;
    endtask

    task automatic rd_cycle();
        @(posedge rd_clk);
        #1;
    endtask

    task automatic t_reset();
        repeat (4) wr_cycle();
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        repeat (3) rd_cycle();
        check(rd_empty == 1'b1, "R1 empty after reset", int'(rd_empty), 1);
        check(wr_full == 1'b0, "R1 full after reset", int'(wr_full), 0);
        check(wr_level == '0, "R1 wr_level after reset", int'(wr_level), 0);
        check(rd_level == '0, "R1 rd_level after reset", int'(rd_level), 0);
    endtask

    task automatic t_fill();
        wr_cycle();
        wr_data = 8'hA0;
        wr_push = 1'b1;
        wr_cycle();
        wr_push = 1'b0;
        rd_cycle();
        check(rd_empty == 1'b1, "R6 empty held by sync delay", int'(rd_empty), 1);
        for (int i = 1; i < DEPTH; i++) begin
            wr_data = 8'(8'hA0 + i);
            wr_push = 1'b1;
            wr_cycle();
            if (i == DEPTH - 2)
                check(wr_full == 1'b0, "R3 not full at DEPTH-1", int'(wr_full), 0);
        end
        wr_push = 1'b0;
        check(wr_full == 1'b1, "R3 full at DEPTH", int'(wr_full), 1);
        check(wr_level == (AW+1)'(DEPTH), "R8 wr_level full", int'(wr_level), DEPTH);
        // pushes into a full FIFO must be dropped
        wr_data = 8'hEE;
        wr_push = 1'b1;
        repeat (3) wr_cycle();
        wr_push = 1'b0;
        check(wr_full == 1'b1, "R4 still full", int'(wr_full), 1);
        check(wr_level == (AW+1)'(DEPTH), "R4 wr_level unchanged", int'(wr_level), DEPTH);
        repeat (8) rd_cycle();
        check(rd_empty == 1'b0, "R6 empty released", int'(rd_empty), 0);
        check(rd_level == (AW+1)'(DEPTH), "R8 rd_level full", int'(rd_level), DEPTH);
        check(rd_data == 8'hA0, "R4 oldest word kept", int'(rd_data), 'hA0);
    endtask

    task automatic t_drain();
        for (int i = 0; i < DEPTH; i++) begin
            check(rd_data == 8'(8'hA0 + i), "R2 read order", int'(rd_data), 'hA0 + i);
            rd_pop = 1'b1;
            rd_cycle();
            if (i == 0)
                check(wr_full == 1'b1, "R7 full held after first pop", int'(wr_full), 1);
        end
        rd_pop = 1'b0;
        check(rd_empty == 1'b1, "R6 empty at last pop", int'(rd_empty), 1);
        check(rd_level == '0, "R8 rd_level drained", int'(rd_level), 0);
        repeat (8) wr_cycle();
        check(wr_full == 1'b0, "R7 full released", int'(wr_full), 0);
        check(wr_level == '0, "R8 wr_level drained", int'(wr_level), 0);
    endtask

    task automatic t_underflow();
        rd_pop = 1'b1;
        repeat (3) rd_cycle();
        rd_pop = 1'b0;
        check(rd_empty == 1'b1, "R5 empty after pops on empty", int'(rd_empty), 1);
        check(rd_level == '0, "R5 rd_level after pops on empty", int'(rd_level), 0);
        wr_data = 8'h5A;
        wr_push = 1'b1;
        wr_cycle();
        wr_push = 1'b0;
        repeat (8) rd_cycle();
        check(rd_data == 8'h5A, "R5 next word presented", int'(rd_data), 'h5A);
        check(rd_level == (AW+1)'(1), "R5 rd_level one entry", int'(rd_level), 1);
        check(wr_level == (AW+1)'(1), "R8 wr_level one entry", int'(wr_level), 1);
        rd_pop = 1'b1;
        rd_cycle();
        rd_pop = 1'b0;
        check(rd_empty == 1'b1, "R6 empty after single pop", int'(rd_empty), 1);
    endtask

    task automatic t_stream();
        fork
            begin : writer
                int n   = 0;
                int cyc = 0;
                while (n < N_STREAM) begin
                    wr_cycle();
                    cyc++;
                    if (!wr_full && (cyc % 5 != 2)) begin
                        wr_data = 8'(n * 37 + 5);
                        wr_push = 1'b1;
                        n++;
                    end else begin
                        wr_push = 1'b0;
                    end
                end
                wr_cycle();
                wr_push = 1'b0;
            end
            begin : reader
                int k   = 0;
                int cyc = 0;
                while (k < N_STREAM) begin
                    rd_cycle();
                    cyc++;
                    if (!rd_empty && (cyc % 3 != 1)) begin
                        check(rd_data == 8'(k * 37 + 5), "R10 stream data",
                              int'(rd_data), (k * 37 + 5) & 255);
                        rd_pop = 1'b1;
                        k++;
                    end else begin
                        rd_pop = 1'b0;
                    end
                end
                rd_cycle();
                rd_pop = 1'b0;
            end
        join
        repeat (8) rd_cycle();
        check(rd_empty == 1'b1, "R10 empty after stream", int'(rd_empty), 1);
        check(wr_level == '0, "R10 wr_level after stream", int'(wr_level), 0);
    endtask

    initial begin
        t_reset();
        t_fill();
        t_drain();
        t_underflow();
        t_stream();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge wr_clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule